// File: doc/BRIEF.md
# Multithreaded Issue Selector with Shared Long-Operation Arbiter

This block picks, for every core in a cluster of small expression cores, which hardware thread issues in the current cycle. Each core carries four thread contexts. Local operations go to fully pipelined units that accept one operation every cycle. Thread choice inside a core is a fixed ranking in which slot 0 always beats slot 1, slot 1 beats slot 2, and so on.

Long operations (logarithm, divide, exponent, float-to-integer conversion) run on one complex unit that the whole cluster shares. A fair rotating arbiter hands that unit to at most one core per cycle. A thread that launches a long operation is marked stalled until its tagged result comes back from the shared unit, and the other threads of its core keep issuing in the meantime. In this block the shared unit is a fixed-latency pipe that carries only the core and thread tags.

A core asks for the shared unit only when its highest-ranked eligible thread wants a long operation. Without a grant, that thread is not ready, and the best lower-ranked thread with a local operation issues in its place. A core with no ready thread issues a bubble.

Top module: `mtIssueCluster`

## Requirements
- R1: After reset no thread is stalled, no result is returning, and the rotating arbiter ranks core 0 first on the first contended request.
- R2: Among a core's ready threads the lowest thread index issues, reported on that core's `issueThread` field (bits `c*2 +: 2`).
- R3: A core with no ready thread drives `issueValid` low for that cycle.
- R4: A stalled thread never issues, and the other threads of the same core keep issuing while it waits.
- R5: A long operation issues only in the cycle its core holds the shared-unit grant, with `issueLong` high; the granted thread reads as stalled from the next cycle on.
- R6: At most one core is granted per cycle, and the grant goes to the first requesting core after the last granted one, counting upward and wrapping from the highest core back to core 0.
- R7: A core requests the shared unit only when its highest-ranked eligible thread has a long operation; while ungranted, its best lower-ranked local-operation thread issues instead.
- R8: The result for a grant appears on `cplxDoneValid` exactly LONG_LAT cycles after the grant, carrying the granted core and thread tags; the thread's stall clears at the following edge.
- R9: The arbiter's rotation point moves only in cycles with a grant.
- R10: A thread whose `thrActive` bit (bit `c*4 + t`) is low never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrActive | input | NUM_CORES*NUM_THREADS | Thread has work left; bit core*NUM_THREADS+thread |
| thrOpLong | input | NUM_CORES*NUM_THREADS | Thread's next operation needs the shared unit |
| issueValid | output | NUM_CORES | Core issues a thread this cycle |
| issueThread | output | NUM_CORES*TW | Issued thread index per core |
| issueLong | output | NUM_CORES | Issued operation goes to the shared unit |
| cplxGrantValid | output | 1 | Shared unit granted this cycle |
| cplxGrantCore | output | CW | Granted core |
| cplxGrantThread | output | TW | Thread launched on the shared unit |
| cplxDoneValid | output | 1 | Shared unit returns a result |
| cplxDoneCore | output | CW | Core tag of the returning result |
| cplxDoneThread | output | TW | Thread tag of the returning result |
| thrStalled | output | NUM_CORES*NUM_THREADS | Per-thread wait flag |

## Verification
Two events can fall in one cycle: a result returning to one thread of a core, and a new grant that stalls another thread of that same core. Both then update the core's stall flags at the same edge. Random stimulus with many threads active and about a third of operations long keeps the shared unit busy enough that returns and grants land together often. Every cycle, a bench model compares the full stall vector and each core's issue choice, so a lost set or a lost clear shows up as a wrong flag or as a thread that issues too early or never again.

// File: rtl/mtIssuePkg.sv
`timescale 1ns/1ps
package mtIssuePkg;
  // Tag width in the control-to-datapath strobe; wide enough for 16 cores or threads.
  localparam int TAG_W = 4;

  typedef struct packed {
    logic             launch;
    logic [TAG_W-1:0] core;
    logic [TAG_W-1:0] thread;
  } cplxStrobe_t;
endpackage

// File: rtl/mtRrArb.sv
`timescale 1ns/1ps
module mtRrArb #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  req,
  output logic          gntValid,
  output logic [IW-1:0] gntIdx
);
  logic [IW-1:0] lastGnt;

  // Search starts just after the last winner; descending k so the nearest wins.
  always_comb begin
    gntValid = 1'b0;
    gntIdx   = '0;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (int'(lastGnt) + k) % N;
      if (req[idx]) begin
        gntValid = 1'b1;
        gntIdx   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastGnt <= IW'(N - 1);
    end else if (gntValid) begin
      lastGnt <= gntIdx;
    end
  end
endmodule

// File: rtl/mtCoreSelect.sv
`timescale 1ns/1ps
module mtCoreSelect #(
  parameter int T = 4,
  localparam int TW = (T > 1) ? $clog2(T) : 1
) (
  input  logic [T-1:0]  thrAct,
  input  logic [T-1:0]  thrLong,
  input  logic [T-1:0]  thrStall,
  input  logic          cplxGnt,
  output logic          cplxReq,
  output logic [TW-1:0] headIdx,
  output logic          issueValid,
  output logic [TW-1:0] issueIdx,
  output logic          issueLong
);
  logic [T-1:0] eligible;
  logic         headValid;
  logic [T-1:0] ready;

  // Highest-ranked eligible thread decides whether the core asks for the shared unit.
  always_comb begin
    eligible  = thrAct & ~thrStall;
    headValid = 1'b0;
    headIdx   = '0;
    for (int t = T - 1; t >= 0; t--) begin
      if (eligible[t]) begin
        headValid = 1'b1;
        headIdx   = TW'(t);
      end
    end
    cplxReq = headValid && thrLong[headIdx];
  end

  // Static priority over ready threads, slot 0 first.
  always_comb begin
    ready = eligible & ~thrLong;
    if (cplxReq && cplxGnt) ready[headIdx] = 1'b1;
    issueValid = 1'b0;
    issueIdx   = '0;
    for (int t = T - 1; t >= 0; t--) begin
      if (ready[t]) begin
        issueValid = 1'b1;
        issueIdx   = TW'(t);
      end
    end
    issueLong = issueValid && thrLong[issueIdx];
  end
endmodule

// File: rtl/mtIssueCtrl.sv
`timescale 1ns/1ps
module mtIssueCtrl
  import mtIssuePkg::*;
#(
  parameter int C = 6,
  parameter int T = 4,
  localparam int TW = (T > 1) ? $clog2(T) : 1,
  localparam int CW = (C > 1) ? $clog2(C) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [C*T-1:0]  thrActive,
  input  logic [C*T-1:0]  thrOpLong,
  input  logic [C*T-1:0]  thrStalled,
  output logic [C-1:0]    issueValid,
  output logic [C*TW-1:0] issueThread,
  output logic [C-1:0]    issueLong,
  output logic            gntValid,
  output logic [CW-1:0]   gntCore,
  output logic [TW-1:0]   gntThread,
  output cplxStrobe_t     strobe
);
  logic [C-1:0]  coreReq;
  logic [TW-1:0] headOf [C];

  mtRrArb #(.N(C)) u_arb (
    .clk     (clk),
    .rstN    (rstN),
    .req     (coreReq),
    .gntValid(gntValid),
    .gntIdx  (gntCore)
  );

  for (genvar c = 0; c < C; c++) begin : g_core
    logic myGnt;
    assign myGnt = gntValid && (gntCore == CW'(c));
    mtCoreSelect #(.T(T)) u_sel (
      .thrAct    (thrActive[c*T +: T]),
      .thrLong   (thrOpLong[c*T +: T]),
      .thrStall  (thrStalled[c*T +: T]),
      .cplxGnt   (myGnt),
      .cplxReq   (coreReq[c]),
      .headIdx   (headOf[c]),
      .issueValid(issueValid[c]),
      .issueIdx  (issueThread[c*TW +: TW]),
      .issueLong (issueLong[c])
    );
  end

  assign gntThread     = headOf[gntCore];
  assign strobe.launch = gntValid;
  assign strobe.core   = TAG_W'(gntCore);
  assign strobe.thread = TAG_W'(gntThread);
endmodule

// File: rtl/mtIssueData.sv
`timescale 1ns/1ps
module mtIssueData
  import mtIssuePkg::*;
#(
  parameter int C   = 6,
  parameter int T   = 4,
  parameter int LAT = 5,
  localparam int TW = (T > 1) ? $clog2(T) : 1,
  localparam int CW = (C > 1) ? $clog2(C) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  cplxStrobe_t    strobe,
  output logic [C*T-1:0] thrStalled,
  output logic           doneValid,
  output logic [CW-1:0]  doneCore,
  output logic [TW-1:0]  doneThread
);
  logic          pipeVld  [LAT];
  logic [CW-1:0] pipeCore [LAT];
  logic [TW-1:0] pipeThr  [LAT];
  logic [C*T-1:0] stallNext;

  // Fixed-latency stand-in for the shared complex unit: carries only tags.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < LAT; s++) begin
        pipeVld[s]  <= 1'b0;
        pipeCore[s] <= '0;
        pipeThr[s]  <= '0;
      end
    end else begin
      pipeVld[0]  <= strobe.launch;
      pipeCore[0] <= CW'(strobe.core);
      pipeThr[0]  <= TW'(strobe.thread);
      for (int s = 1; s < LAT; s++) begin
        pipeVld[s]  <= pipeVld[s-1];
        pipeCore[s] <= pipeCore[s-1];
        pipeThr[s]  <= pipeThr[s-1];
      end
    end
  end

  assign doneValid  = pipeVld[LAT-1];
  assign doneCore   = pipeCore[LAT-1];
  assign doneThread = pipeThr[LAT-1];

  always_comb begin
    stallNext = thrStalled;
    if (doneValid) stallNext[int'(doneCore)*T + int'(doneThread)] = 1'b0;
    if (strobe.launch) stallNext[int'(strobe.core)*T + int'(strobe.thread)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) thrStalled <= '0;
    else       thrStalled <= stallNext;
  end
endmodule

// File: rtl/mtIssueCluster.sv
`timescale 1ns/1ps
module mtIssueCluster
  import mtIssuePkg::*;
#(
  parameter int NUM_CORES   = 6,
  parameter int NUM_THREADS = 4,
  parameter int LONG_LAT    = 5,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CORES*NUM_THREADS-1:0] thrActive,
  input  logic [NUM_CORES*NUM_THREADS-1:0] thrOpLong,
  output logic [NUM_CORES-1:0]            issueValid,
  output logic [NUM_CORES*TW-1:0]         issueThread,
  output logic [NUM_CORES-1:0]            issueLong,
  output logic                            cplxGrantValid,
  output logic [CW-1:0]                   cplxGrantCore,
  output logic [TW-1:0]                   cplxGrantThread,
  output logic                            cplxDoneValid,
  output logic [CW-1:0]                   cplxDoneCore,
  output logic [TW-1:0]                   cplxDoneThread,
  output logic [NUM_CORES*NUM_THREADS-1:0] thrStalled
);
  cplxStrobe_t strobe;

  mtIssueCtrl #(.C(NUM_CORES), .T(NUM_THREADS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .thrActive  (thrActive),
    .thrOpLong  (thrOpLong),
    .thrStalled (thrStalled),
    .issueValid (issueValid),
    .issueThread(issueThread),
    .issueLong  (issueLong),
    .gntValid   (cplxGrantValid),
    .gntCore    (cplxGrantCore),
    .gntThread  (cplxGrantThread),
    .strobe     (strobe)
  );

  mtIssueData #(.C(NUM_CORES), .T(NUM_THREADS), .LAT(LONG_LAT)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .thrStalled(thrStalled),
    .doneValid (cplxDoneValid),
    .doneCore  (cplxDoneCore),
    .doneThread(cplxDoneThread)
  );
endmodule

// File: rtl/mtIssueCluster_chk.sv
`timescale 1ns/1ps
module mtIssueCluster_chk #(
  parameter int NUM_CORES   = 6,
  parameter int NUM_THREADS = 4,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_CORES*NUM_THREADS-1:0] thrActive,
  input logic [NUM_CORES-1:0]             issueValid,
  input logic [NUM_CORES*TW-1:0]          issueThread,
  input logic [NUM_CORES-1:0]             issueLong,
  input logic                             cplxGrantValid,
  input logic [CW-1:0]                    cplxGrantCore,
  input logic [TW-1:0]                    cplxGrantThread,
  input logic                             cplxDoneValid,
  input logic [CW-1:0]                    cplxDoneCore,
  input logic [TW-1:0]                    cplxDoneThread,
  input logic [NUM_CORES*NUM_THREADS-1:0] thrStalled
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R10
    issue_active_chk: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[c] |-> thrActive[c*NUM_THREADS + int'(issueThread[c*TW +: TW])]);
    // R4
    issue_not_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[c] |-> !thrStalled[c*NUM_THREADS + int'(issueThread[c*TW +: TW])]);
    // R5
    long_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid[c] && issueLong[c]) |-> (cplxGrantValid && cplxGrantCore == CW'(c)));
  end

  // R6
  grant_matches_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplxGrantValid |-> (issueValid[cplxGrantCore] && issueLong[cplxGrantCore]
                        && issueThread[int'(cplxGrantCore)*TW +: TW] == cplxGrantThread));
  // R5
  grant_sets_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplxGrantValid |=> thrStalled[int'($past(cplxGrantCore))*NUM_THREADS + int'($past(cplxGrantThread))]);
  // R8
  done_was_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplxDoneValid |-> thrStalled[int'(cplxDoneCore)*NUM_THREADS + int'(cplxDoneThread)]);
  // R8
  done_clears_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplxDoneValid |=> !thrStalled[int'($past(cplxDoneCore))*NUM_THREADS + int'($past(cplxDoneThread))]);
endmodule

bind mtIssueCluster mtIssueCluster_chk #(.NUM_CORES(NUM_CORES), .NUM_THREADS(NUM_THREADS)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .thrActive      (thrActive),
  .issueValid     (issueValid),
  .issueThread    (issueThread),
  .issueLong      (issueLong),
  .cplxGrantValid (cplxGrantValid),
  .cplxGrantCore  (cplxGrantCore),
  .cplxGrantThread(cplxGrantThread),
  .cplxDoneValid  (cplxDoneValid),
  .cplxDoneCore   (cplxDoneCore),
  .cplxDoneThread (cplxDoneThread),
  .thrStalled     (thrStalled)
);

// File: tb/mtIssueCluster_tb.sv
`timescale 1ns/1ps
module mtIssueCluster_tb;
  localparam int CLK_PERIOD = 10;
  localparam int C   = 6;
  localparam int T   = 4;
  localparam int LAT = 5;
  localparam int TW  = 2;
  localparam int CW  = 3;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [C*T-1:0] thrActive = '0;
  logic [C*T-1:0] thrOpLong = '0;
  logic [C-1:0]    issueValid, issueLong;
  logic [C*TW-1:0] issueThread;
  logic            cplxGrantValid, cplxDoneValid;
  logic [CW-1:0]   cplxGrantCore, cplxDoneCore;
  logic [TW-1:0]   cplxGrantThread, cplxDoneThread;
  logic [C*T-1:0]  thrStalled;

  int nChecks = 0;
  int nFail = 0;

  // Reference state kept by the bench
  bit mStall [C*T];
  int mPtr;
  bit pVld [LAT];
  int pCore [LAT];
  int pThr [LAT];
  // Expected values for the current cycle
  bit eIssV [C];
  int eIssT [C];
  bit eIssL [C];
  int eHead [C];
  bit eGntV;
  int eGntC, eGntT;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtIssueCluster #(.NUM_CORES(C), .NUM_THREADS(T), .LONG_LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .thrActive(thrActive), .thrOpLong(thrOpLong),
    .issueValid(issueValid), .issueThread(issueThread), .issueLong(issueLong),
    .cplxGrantValid(cplxGrantValid), .cplxGrantCore(cplxGrantCore),
    .cplxGrantThread(cplxGrantThread), .cplxDoneValid(cplxDoneValid),
    .cplxDoneCore(cplxDoneCore), .cplxDoneThread(cplxDoneThread),
    .thrStalled(thrStalled)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < C*T; i++) mStall[i] = 1'b0;
    for (int s = 0; s < LAT; s++) begin pVld[s] = 1'b0; pCore[s] = 0; pThr[s] = 0; end
    mPtr = C - 1;
  endtask

  task automatic modelEval();
    bit req [C];
    for (int c = 0; c < C; c++) begin
      eHead[c] = -1;
      for (int t = T - 1; t >= 0; t--)
        if (thrActive[c*T+t] && !mStall[c*T+t]) eHead[c] = t;
      req[c] = (eHead[c] >= 0) && thrOpLong[c*T + ((eHead[c] < 0) ? 0 : eHead[c])];
    end
    eGntV = 1'b0; eGntC = 0; eGntT = 0;
    for (int k = C; k >= 1; k--) begin
      int idx;
      idx = (mPtr + k) % C;
      if (req[idx]) begin eGntV = 1'b1; eGntC = idx; eGntT = eHead[idx]; end
    end
    for (int c = 0; c < C; c++) begin
      eIssV[c] = 1'b0; eIssT[c] = 0; eIssL[c] = 1'b0;
      for (int t = T - 1; t >= 0; t--) begin
        bit ok;
        ok = thrActive[c*T+t] && !mStall[c*T+t] &&
             (!thrOpLong[c*T+t] || (eGntV && eGntC == c && eGntT == t));
        if (ok) begin eIssV[c] = 1'b1; eIssT[c] = t; eIssL[c] = thrOpLong[c*T+t]; end
      end
    end
  endtask

  task automatic modelCommit();
    if (pVld[LAT-1]) mStall[pCore[LAT-1]*T + pThr[LAT-1]] = 1'b0;
    if (eGntV) mStall[eGntC*T + eGntT] = 1'b1;
    for (int s = LAT - 1; s >= 1; s--) begin
      pVld[s] = pVld[s-1]; pCore[s] = pCore[s-1]; pThr[s] = pThr[s-1];
    end
    pVld[0] = eGntV; pCore[0] = eGntC; pThr[0] = eGntT;
    if (eGntV) mPtr = eGntC;
  endtask

  task automatic compareAll();
    logic [C*T-1:0] expStall;
    for (int c = 0; c < C; c++) begin
      check(issueValid[c] == eIssV[c], "R2/R3/R4/R10", $sformatf("issueValid core%0d", c),
            int'(issueValid[c]), int'(eIssV[c]));
      if (eIssV[c] && issueValid[c]) begin
        check(int'(issueThread[c*TW +: TW]) == eIssT[c], "R2/R7", $sformatf("issueThread core%0d", c),
              int'(issueThread[c*TW +: TW]), eIssT[c]);
        check(issueLong[c] == eIssL[c], "R5", $sformatf("issueLong core%0d", c),
              int'(issueLong[c]), int'(eIssL[c]));
      end
    end
    check(cplxGrantValid == eGntV, "R6/R9", "grantValid", int'(cplxGrantValid), int'(eGntV));
    if (eGntV && cplxGrantValid) begin
      check(int'(cplxGrantCore) == eGntC, "R6/R9", "grantCore", int'(cplxGrantCore), eGntC);
      check(int'(cplxGrantThread) == eGntT, "R7", "grantThread", int'(cplxGrantThread), eGntT);
    end
    check(cplxDoneValid == pVld[LAT-1], "R8", "doneValid", int'(cplxDoneValid), int'(pVld[LAT-1]));
    if (pVld[LAT-1] && cplxDoneValid) begin
      check(int'(cplxDoneCore) == pCore[LAT-1], "R8", "doneCore", int'(cplxDoneCore), pCore[LAT-1]);
      check(int'(cplxDoneThread) == pThr[LAT-1], "R8", "doneThread", int'(cplxDoneThread), pThr[LAT-1]);
    end
    for (int i = 0; i < C*T; i++) expStall[i] = mStall[i];
    check(thrStalled == expStall, "R5/R8", "thrStalled", int'(thrStalled), int'(expStall));
  endtask

  // Sample just before the rising edge, after inputs settled at the falling edge.
  task automatic sampleNow();
    #(CLK_PERIOD/2 - 1);
    modelEval();
    compareAll();
  endtask

  task automatic advance();
    modelCommit();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 and R3: clean state after reset, idle inputs give a bubble everywhere
    sampleNow();
    check(thrStalled == '0, "R1", "stall after reset", int'(thrStalled), 0);
    check(cplxDoneValid == 1'b0, "R1", "done after reset", int'(cplxDoneValid), 0);
    check(issueValid == '0, "R3", "bubble with no ready thread", int'(issueValid), 0);
    advance();

    // R2 and R10: slot 0 inactive, slots 1 and 2 local -> slot 1 issues
    thrActive = '0; thrOpLong = '0;
    thrActive[1] = 1'b1; thrActive[2] = 1'b1;
    sampleNow();
    check(issueValid[0] && issueThread[1:0] == 2'd1, "R2/R10", "core0 picks slot1",
          int'(issueThread[1:0]), 1);
    advance();

    // R1 and R6: every core's slot 0 wants a long op; core 0 first, then core 1
    thrActive = '0; thrOpLong = '0;
    for (int c = 0; c < C; c++) begin thrActive[c*T] = 1'b1; thrOpLong[c*T] = 1'b1; end
    sampleNow();
    check(cplxGrantValid && cplxGrantCore == 3'd0, "R1", "first grant to core0", int'(cplxGrantCore), 0);
    advance();
    sampleNow();
    check(cplxGrantValid && cplxGrantCore == 3'd1, "R6", "rotation to core1", int'(cplxGrantCore), 1);
    check(issueValid[0] == 1'b0, "R4", "stalled slot0 of core0 silent", int'(issueValid[0]), 0);
    advance();

    // R7: core 5 head wants a long op but core 2 wins; core 5 issues local slot 2
    thrActive = '0; thrOpLong = '0;
    thrActive[2*T] = 1'b1; thrOpLong[2*T] = 1'b1;
    thrActive[5*T] = 1'b1; thrOpLong[5*T] = 1'b1; thrActive[5*T+2] = 1'b1;
    sampleNow();
    check(cplxGrantValid && cplxGrantCore == 3'd2, "R6", "grant core2", int'(cplxGrantCore), 2);
    check(issueValid[5] && issueThread[5*TW +: TW] == 2'd2 && !issueLong[5], "R7",
          "core5 falls back to local slot2", int'(issueThread[5*TW +: TW]), 2);
    advance();

    // R4: core 0 slot 0 still stalled, slot 3 local keeps issuing
    thrActive = '0; thrOpLong = '0;
    thrActive[0] = 1'b1; thrOpLong[0] = 1'b1; thrActive[3] = 1'b1;
    sampleNow();
    check(issueValid[0] && issueThread[1:0] == 2'd3, "R4", "other thread keeps issuing",
          int'(issueThread[1:0]), 3);
    advance();

    // R8: drain returning results with idle inputs
    thrActive = '0; thrOpLong = '0;
    for (int i = 0; i < LAT + 2; i++) begin sampleNow(); advance(); end
    sampleNow();
    check(thrStalled == '0, "R8", "all stalls cleared after drain", int'(thrStalled), 0);
    advance();

    // Random traffic: many overlapping grants and returns
    for (int n = 0; n < N_RAND; n++) begin
      for (int i = 0; i < C*T; i++) begin
        thrActive[i] = ($urandom % 4) != 0;
        thrOpLong[i] = ($urandom % 10) < 3;
      end
      sampleNow();
      advance();
    end

    summary();
    $finish;
  end
endmodule